// File: doc/BRIEF.md
# Soft Interrupt Register with Level Gating

This block keeps a 17-bit software interrupt register next to a 4-bit processor interrupt level. Software changes the register in three ways. It can overwrite it, OR bits into it through a set alias, or remove bits through a clear alias. Two timer-match inputs also raise dedicated bits: a tick match raises bit 0 and a system-tick match raises bit 16.

The block drives a 17-line pending vector from the registered contents and the registered level. Bits 1 to 15 each stand for an interrupt level, and a level-bit is pending only when its level is strictly above the current interrupt level. The two timer bits use a fixed threshold instead: each is pending while the interrupt level is below 14. The register and the level are both readable.

The write buses are 32 bits wide. Only the low 17 bits reach the register. Choosing among pending lines and delivering traps belong to the consumer.

Top module: `softint_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the register, the interrupt level and every pending line are zero until the first write.
- R2: A direct write (`wr_en`) loads the low 17 bits of `wr_data`; the new value is on `rd_data` after the next rising clock edge.
- R3: A set-alias write (`set_en`) stores the current value OR the low 17 bits of `set_data`.
- R4: A clear-alias write (`clr_en`) stores the current value AND NOT the low 17 bits of `clr_data`.
- R5: When several write ports are active in one cycle they apply in a fixed order: the direct write first, then the set alias on its result, then the clear alias on that result.
- R6: `tick_match` sets bit 0 and `stick_match` sets bit 16 after the three write ports have been applied, so a same-cycle clear never hides a timer match.
- R7: Pending bits 0 and 16 are high exactly when the matching register bit is set and the interrupt level is below 14.
- R8: Pending bit n, for n from 1 to 15, is high exactly when register bit n is set and n is strictly greater than the interrupt level.
- R9: The pending vector reflects the register and the interrupt level as they stand after the most recent clock edge, with no further delay.
- R10: Bits 31 to 17 of every write bus have no effect, and bits 31 to 17 of `rd_data` always read zero.
- R11: `pil_wr_en` loads `pil_wr_data` into the interrupt level, which is visible on `pil_q`; without it the level holds.
- R12: With no write and no timer match, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | 32 | Direct write value |
| set_en | input | 1 | Set-alias write strobe |
| set_data | input | 32 | Bits to OR into the register |
| clr_en | input | 1 | Clear-alias write strobe |
| clr_data | input | 32 | Bits to remove from the register |
| pil_wr_en | input | 1 | Interrupt level write strobe |
| pil_wr_data | input | 4 | New interrupt level |
| tick_match | input | 1 | Tick timer match, sets bit 0 |
| stick_match | input | 1 | System-tick timer match, sets bit 16 |
| rd_data | output | 32 | Register value, zero-extended |
| pil_q | output | 4 | Current interrupt level |
| pending | output | 17 | Level-gated pending lines |

## Verification
Several things can land on the register in the same clock: the direct, set and clear ports can fire together, and a timer match can coincide with a clear that names its bit. The bench drives these collisions deliberately. It also runs a long pseudo-random stream in which every port and both timer inputs are toggled independently. Each result is judged against an arithmetic model that applies overwrite, OR, AND-NOT and then the timer bits in that order, and against gating computed from the level. A level write that coincides with a register write is covered as well, because the pending vector must then follow both new values at once.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int SOFTINT_LEVELS    = 15;
  localparam int SOFTINT_PIL_W     = 4;
  localparam int SOFTINT_TMR_LIMIT = 14;
  localparam int SOFTINT_DATA_W    = 32;

  typedef struct packed {
    logic stick;
    logic tick;
  } tmr_hit_t;
endpackage

// File: rtl/softint_rst_sync.sv
module softint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/softint_pil_reg.sv
module softint_pil_reg #(
  parameter int PIL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pil_en,
  input  logic [PIL_W-1:0] pil_d,
  output logic [PIL_W-1:0] pil_q
);
  logic [PIL_W-1:0] pil_nxt;

  always_comb begin
    pil_nxt = pil_q;
    if (pil_en) pil_nxt = pil_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pil_q <= '0;
    else if (pil_en) pil_q <= pil_nxt;
  end

  assert_pil_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pil_en |=> $stable(pil_q));
  assert_pil_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pil_en |=> (pil_q == $past(pil_d)));
endmodule

// File: rtl/softint_reg_core.sv
module softint_reg_core
  import softint_pkg::*;
#(
  parameter int REG_W  = 17,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  tmr_hit_t          hit,
  output logic [REG_W-1:0]  val_q
);
  localparam int TOP = REG_W - 1;

  logic [REG_W-1:0] wr_m, set_m, clr_m, tmr_m;
  logic [REG_W-1:0] after_wr, after_set, after_clr, val_nxt;
  logic             upd_en;

  assign wr_m  = wr_data[REG_W-1:0];
  assign set_m = set_data[REG_W-1:0];
  assign clr_m = clr_data[REG_W-1:0];

  always_comb begin
    tmr_m      = '0;
    tmr_m[0]   = hit.tick;
    tmr_m[TOP] = hit.stick;
  end

  always_comb begin
    after_wr  = wr_en  ? wr_m : val_q;
    after_set = set_en ? (after_wr | set_m) : after_wr;
    after_clr = clr_en ? (after_set & ~clr_m) : after_set;
    val_nxt   = after_clr | tmr_m;
  end

  assign upd_en = wr_en | set_en | clr_en | hit.tick | hit.stick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (upd_en) val_q <= val_nxt;
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(val_q));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !hit.tick && !hit.stick) |=> ((val_q & $past(clr_m)) == '0));
  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((val_q & $past(set_m)) == $past(set_m)));
  assert_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit.tick |=> val_q[0]);
  assert_stick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit.stick |=> val_q[TOP]);
  assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_en && !clr_en && !hit.tick && !hit.stick) |=> (val_q == $past(wr_m)));
endmodule

// File: rtl/softint_gate.sv
module softint_gate #(
  parameter int REG_W     = 17,
  parameter int PIL_W     = 4,
  parameter int TMR_LIMIT = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] val,
  input  logic [PIL_W-1:0] pil,
  output logic [REG_W-1:0] pend
);
  localparam int TOP = REG_W - 1;

  logic tmr_open;
  assign tmr_open = (32'(pil) < 32'(TMR_LIMIT));

  for (genvar n = 0; n < REG_W; n++) begin : g_line
    if (n == 0 || n == TOP) begin : g_tmr
      assign pend[n] = val[n] & tmr_open;
    end else begin : g_lvl
      assign pend[n] = val[n] & (32'(n) > 32'(pil));
    end
  end

  assert_tmr_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pil) >= 32'(TMR_LIMIT)) |-> (!pend[0] && !pend[TOP]));
endmodule

// File: rtl/softint_ctrl.sv
module softint_ctrl
  import softint_pkg::*;
#(
  parameter int LEVELS    = SOFTINT_LEVELS,
  parameter int PIL_W     = SOFTINT_PIL_W,
  parameter int TMR_LIMIT = SOFTINT_TMR_LIMIT,
  parameter int DATA_W    = SOFTINT_DATA_W,
  localparam int REG_W    = LEVELS + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_data,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_data,
  input  logic              pil_wr_en,
  input  logic [PIL_W-1:0]  pil_wr_data,
  input  logic              tick_match,
  input  logic              stick_match,
  output logic [DATA_W-1:0] rd_data,
  output logic [PIL_W-1:0]  pil_q,
  output logic [REG_W-1:0]  pending
);
  logic             rst_sync_n;
  logic [REG_W-1:0] val_q;
  tmr_hit_t         hit;

  assign hit.tick  = tick_match;
  assign hit.stick = stick_match;

  softint_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  softint_pil_reg #(.PIL_W(PIL_W)) u_pil (
    .clk(clk), .rst_n(rst_sync_n), .pil_en(pil_wr_en),
    .pil_d(pil_wr_data), .pil_q(pil_q)
  );

  softint_reg_core #(.REG_W(REG_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .set_en(set_en), .set_data(set_data),
    .clr_en(clr_en), .clr_data(clr_data),
    .hit(hit), .val_q(val_q)
  );

  softint_gate #(.REG_W(REG_W), .PIL_W(PIL_W), .TMR_LIMIT(TMR_LIMIT)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .val(val_q), .pil(pil_q), .pend(pending)
  );

  if (DATA_W > REG_W) begin : g_ext
    assign rd_data = {{(DATA_W-REG_W){1'b0}}, val_q};
  end else begin : g_fit
    assign rd_data = val_q;
  end

  assert_pend_subset_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pending & ~rd_data[REG_W-1:0]) == '0));
  assert_lvl_top_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pil_q == '1) |-> (pending[REG_W-2:1] == '0));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (pending == '0));
endmodule

// File: tb/softint_ctrl_bench.sv
module softint_ctrl_bench;
  localparam int DW = 32;
  localparam int RW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, set_en, clr_en, pil_wr_en, tick_match, stick_match;
  logic [DW-1:0] wr_data, set_data, clr_data;
  logic [3:0]    pil_wr_data;
  logic [DW-1:0] rd_data;
  logic [3:0]    pil_q;
  logic [RW-1:0] pending;

  int total = 0;
  int bad   = 0;
  logic [RW-1:0] m;
  logic [3:0]    mp;

  always #5 clk = ~clk;

  softint_ctrl u_softint_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .set_en(set_en), .set_data(set_data),
    .clr_en(clr_en), .clr_data(clr_data),
    .pil_wr_en(pil_wr_en), .pil_wr_data(pil_wr_data),
    .tick_match(tick_match), .stick_match(stick_match),
    .rd_data(rd_data), .pil_q(pil_q), .pending(pending)
  );

  function automatic logic [RW-1:0] exp_pend(input logic [RW-1:0] r, input logic [3:0] p);
    logic [RW-1:0] e;
    e = '0;
    e[0]  = r[0]  && (p < 4'd14);
    e[16] = r[16] && (p < 4'd14);
    for (int n = 1; n < 16; n++) e[n] = r[n] && (n > int'(p));
    return e;
  endfunction

  task automatic check(input string req);
    total++;
    if (rd_data !== {15'd0, m}) begin
      bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, {15'd0, m});
    end
    total++;
    if (pil_q !== mp) begin
      bad++;
      $display("FAIL %s pil_q actual=%h expected=%h", req, pil_q, mp);
    end
    total++;
    if (pending !== exp_pend(m, mp)) begin
      bad++;
      $display("FAIL %s pending actual=%h expected=%h", req, pending, exp_pend(m, mp));
    end
  endtask

  task automatic op(input logic we, input logic [DW-1:0] wd,
                    input logic se, input logic [DW-1:0] sd,
                    input logic ce, input logic [DW-1:0] cd,
                    input logic pe, input logic [3:0] pd,
                    input logic tk, input logic st);
    logic [RW-1:0] t;
    wr_en = we; wr_data = wd; set_en = se; set_data = sd;
    clr_en = ce; clr_data = cd; pil_wr_en = pe; pil_wr_data = pd;
    tick_match = tk; stick_match = st;
    @(negedge clk);
    wr_en = 0; set_en = 0; clr_en = 0; pil_wr_en = 0; tick_match = 0; stick_match = 0;
    t = we ? wd[RW-1:0] : m;
    if (se) t = t | sd[RW-1:0];
    if (ce) t = t & ~cd[RW-1:0];
    if (tk) t[0] = 1'b1;
    if (st) t[16] = 1'b1;
    m = t;
    if (pe) mp = pd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    m = '0; mp = '0;
    rst_n = 1'b0;
    wr_en = 0; set_en = 0; clr_en = 0; pil_wr_en = 0; tick_match = 0; stick_match = 0;
    wr_data = '0; set_data = '0; clr_data = '0; pil_wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    op(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 R10 direct all ones");
    op(1, 32'h0001_2345, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 direct pattern");

    for (int p = 0; p < 16; p++) begin
      op(0, 0, 0, 0, 0, 0, 1, 4'(p), 0, 0);
      check("R11 level load");
      for (int b = 0; b < RW; b++) begin
        op(1, 32'(1) << b, 0, 0, 0, 0, 0, 0, 0, 0);
        check((b == 0 || b == 16) ? "R7 timer gate" : "R8 level gate");
      end
      op(1, 32'h0001_FFFF, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R9 all set");
    end

    op(1, 0, 1, 32'h0000_00A5, 0, 0, 1, 4'd2, 0, 0);
    check("R3 R9 set with level write");
    op(0, 0, 1, 32'hFFF1_0000, 0, 0, 0, 0, 0, 0);
    check("R3 R10 set upper bits");
    op(0, 0, 0, 0, 1, 32'h0000_0005, 0, 0, 0, 0);
    check("R4 clear");
    op(0, 0, 0, 0, 1, 32'hFFFE_0000, 0, 0, 0, 0);
    check("R4 R10 clear upper bits ignored");
    op(1, 32'h0000_0F0F, 1, 32'h0000_00F0, 1, 32'h0000_0101, 0, 0, 0, 0);
    check("R5 all three ports");
    op(1, 32'h0000_1000, 1, 32'h0000_0001, 0, 0, 0, 0, 0, 0);
    check("R5 direct then set");
    op(0, 0, 1, 32'h0000_0300, 1, 32'h0000_0100, 0, 0, 0, 0);
    check("R5 set then clear");
    op(0, 0, 0, 0, 1, 32'h0001_FFFF, 0, 0, 1, 1);
    check("R6 timers beat clear");
    op(0, 0, 0, 0, 1, 32'h0001_FFFF, 1, 4'd13, 0, 0);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    check("R6 R7 tick match");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R6 R7 stick match");
    op(0, 0, 0, 0, 0, 0, 1, 4'd14, 0, 0);
    check("R7 R11 level at threshold");
    repeat (3) begin
      @(negedge clk);
      check("R12 R11 idle hold");
    end

    s = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b2, c;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); a = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); b2 = s;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5); c = s;
      op(a[0] & a[1], b2, a[2], c, a[3], {b2[15:0], c[31:16]},
         a[4], a[11:8], a[5] & a[6], a[7] & a[12]);
      check("R5 R6 R9 random stream");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule